// File: doc/BRIEF.md
# Central Bus Arbiter with Tenure Timers

This block is the single arbitration point for a shared parallel bus with several masters. Each master has a private active-low request line and a private active-low grant line. Requests are evaluated on every clock, including while another master is transferring. The grant can therefore move to the next master during a burst, and the new master starts as soon as it sees the bus idle. When nobody requests, the grant stays parked on the last master that held it. Rotating priority picks the next grantee, starting the search just after the current grantee.

For each master the block keeps a tenure timer. The timer is reloaded from that master's 8-bit setting when the master begins a transaction. It counts down on every clock while the bus is busy with that master's transaction. A per-master terminate flag tells the owner that it must wrap up its burst. The flag rises only when both of these hold:
- the owner's timer has reached zero, and
- the owner's grant has been taken away.

An owner whose grant was removed early still keeps the bus until its timer runs out. An owner that is still granted may burst for as long as it likes. The bus is seen as busy from the first sampled assertion of the frame signal until both the frame and initiator-ready signals are sampled deasserted.

The grant controller has three states:
- GR_NONE: nothing granted, which is only possible after reset.
- GR_PENDING: granted, but the grantee has not yet started a transaction under this grant.
- GR_USED: the grantee has started a transaction under this grant.

Its transitions are:
- NONE to PENDING on any request (first grant).
- PENDING to PENDING when the grantee drops its request while another master requests (withdrawn request handoff).
- PENDING to USED when the grantee starts a transaction (take-up).
- USED to PENDING when any other master requests (hidden handoff).

The bus tracker has two states, BUS_IDLE and BUS_ACTIVE. It goes IDLE to ACTIVE when the frame signal is sampled low (start). It goes ACTIVE to IDLE when frame and initiator-ready are both sampled high (release).

Top module: `tenure_arbiter`

## Requirements
- R1: While reset is held and right after it, every `gnt_n` bit is 1 and every `must_end` bit is 0.
- R2: At most one `gnt_n` bit is 0 at any time. When nothing is granted and any `req_n` bit is sampled 0, a grant is driven in the next cycle.
- R3: Bit position k of `req_n`, `gnt_n` and `must_end` belongs to master k. The grant search runs from the current grantee index plus one upward and wraps at N_MASTERS. Before the first grant the search starts at master 0.
- R4: With all `req_n` bits sampled 1, `gnt_n` keeps its value (parking).
- R5: Suppose the grantee has started a transaction under its current grant and another master requests. The grant then moves on the next clock, even while the bus is busy.
- R6: A grantee that has not yet started a transaction and still requests keeps its grant, whatever other masters request.
- R7: On the start clock, the owner's timer loads `lat_reload[8k+7:8k]`. It then decrements once on each later clock while the bus is busy, stopping at zero. With reload value L, the timer reaches zero L clocks after the start clock.
- R8: `must_end[k]` is 1 exactly when all of these hold, so it is never 1 while `gnt_n[k]` is 0:
  - the bus is busy,
  - master k is the owner,
  - master k's timer is zero,
  - `gnt_n[k]` is 1.
- R9: The bus becomes busy at a clock where `frame_n` is sampled 0 while idle. It becomes idle at a clock where `frame_n` and `irdy_n` are both sampled 1. While idle, all `must_end` bits are 0.
- R10: The owner of a new transaction is the master whose `gnt_n` bit was 0 in the cycle just before the start clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_MASTERS | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low transaction frame from the bus |
| irdy_n | input | 1 | Active-low initiator ready from the bus |
| lat_reload | input | 8*N_MASTERS | Per-master 8-bit tenure reload value, master k at bits 8k+7:8k |
| gnt_n | output | N_MASTERS | Active-low grant, one bit per master |
| must_end | output | N_MASTERS | Active-high terminate indication for the owning master |

## Verification
A directed part applies simultaneous requests from reset to show where the rotating search starts. It holds a request without starting to separate the pending hold from the hidden handoff, and drops all requests to show parking. Two bursts follow. In the first, a long burst with nobody else requesting shows that an expired timer alone never raises the terminate flag. In the second, a burst with a competitor pins the exact clock on which the flag rises relative to the reload value. A seeded random part then flips request bits at random and runs a bus master model that starts on a sampled grant and ends on a random length or on the flag. This mixes handoffs that occur during bursts, at idle, and with zero reload values, and compares every cycle against a reference model.

// File: rtl/tenure_arb_pkg.sv
package tenure_arb_pkg;
    typedef enum logic {
        BUS_IDLE,
        BUS_ACTIVE
    } bus_state_e;

    typedef enum logic [1:0] {
        GR_NONE,
        GR_PENDING,
        GR_USED
    } grant_state_e;
endpackage

// File: rtl/bus_tracker.sv
module bus_tracker
    import tenure_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic active,
    output logic start
);
    bus_state_e state_q, state_d;

    // next-state: start when frame seen low, release when both high (R9)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (!frame_n)           state_d = BUS_ACTIVE;
            BUS_ACTIVE: if (frame_n && irdy_n)  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == BUS_ACTIVE);
        start  = (state_q == BUS_IDLE) && !frame_n;
    end
endmodule

// File: rtl/rr_select.sv
module rr_select #(
    parameter int N_MASTERS = 4,
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]     base,
    output logic                 hit,
    output logic [IDX_W-1:0]     sel
);
    // scan offsets from far to near so the nearest requester after base wins (R3)
    always_comb begin
        hit = 1'b0;
        sel = base;
        for (int off = N_MASTERS; off >= 1; off--) begin
            int cand;
            cand = (int'(base) + off) % N_MASTERS;
            if (req[cand]) begin
                hit = 1'b1;
                sel = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             count_en,
    input  logic [TMR_W-1:0] reload,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    // load at transaction start, then count busy clocks down to zero (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= reload;
        else if (count_en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tenure_arbiter.sv
module tenure_arbiter
    import tenure_arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int TMR_W     = 8,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_MASTERS-1:0]       req_n,
    input  logic                       frame_n,
    input  logic                       irdy_n,
    input  logic [N_MASTERS*TMR_W-1:0] lat_reload,
    output logic [N_MASTERS-1:0]       gnt_n,
    output logic [N_MASTERS-1:0]       must_end
);
    localparam logic [N_MASTERS-1:0] ONE_HOT0 = {{(N_MASTERS-1){1'b0}}, 1'b1};

    grant_state_e          gst_q, gst_d;
    logic [IDX_W-1:0]      gidx_q, gidx_d;
    logic [IDX_W-1:0]      pidx_q;
    logic                  pvalid_q;
    logic [IDX_W-1:0]      owner_q;
    logic                  owner_v_q;

    logic [N_MASTERS-1:0]  req;
    logic [N_MASTERS-1:0]  cur_oh;
    logic [N_MASTERS-1:0]  others;
    logic                  cur_req;
    logic                  rr_hit;
    logic [IDX_W-1:0]      rr_sel;
    logic                  bus_active;
    logic                  bus_start;
    logic                  take_up;
    logic [N_MASTERS-1:0]  tmr_zero;

    assign req     = ~req_n;
    assign cur_oh  = (gst_q != GR_NONE) ? (ONE_HOT0 << gidx_q) : '0;
    assign others  = req & ~cur_oh;
    assign cur_req = req[gidx_q];
    // R10: the starter is the master granted in the cycle before the start clock
    assign take_up = bus_start && pvalid_q;

    bus_tracker u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .active  (bus_active),
        .start   (bus_start)
    );

    rr_select #(.N_MASTERS(N_MASTERS)) u_rr (
        .req  (req),
        .base (gidx_q),
        .hit  (rr_hit),
        .sel  (rr_sel)
    );

    // grant state machine: next state and next grantee
    always_comb begin
        gst_d  = gst_q;
        gidx_d = gidx_q;
        unique case (gst_q)
            GR_NONE: begin
                if (rr_hit) begin
                    gidx_d = rr_sel;
                    gst_d  = GR_PENDING;
                end
            end
            GR_PENDING: begin
                if (others != '0 && !cur_req) begin
                    gidx_d = rr_sel;
                    gst_d  = GR_PENDING;
                end else if (take_up && pidx_q == gidx_q) begin
                    gst_d  = GR_USED;
                end
            end
            GR_USED: begin
                if (others != '0) begin
                    gidx_d = rr_sel;
                    gst_d  = GR_PENDING;
                end
            end
            default: gst_d = GR_NONE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gst_q     <= GR_NONE;
            gidx_q    <= IDX_W'(N_MASTERS - 1);
            pidx_q    <= '0;
            pvalid_q  <= 1'b0;
            owner_q   <= '0;
            owner_v_q <= 1'b0;
        end else begin
            gst_q    <= gst_d;
            gidx_q   <= gidx_d;
            pidx_q   <= gidx_q;
            pvalid_q <= (gst_q != GR_NONE);
            if (take_up) begin
                owner_q   <= pidx_q;
                owner_v_q <= 1'b1;
            end
        end
    end

    // per-master tenure timers and terminate flags
    for (genvar k = 0; k < N_MASTERS; k++) begin : g_master
        logic is_owner;
        assign is_owner = owner_v_q && (owner_q == IDX_W'(k));

        tenure_timer #(.TMR_W(TMR_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (take_up && pidx_q == IDX_W'(k)),
            .count_en (bus_active && is_owner),
            .reload   (lat_reload[k*TMR_W +: TMR_W]),
            .expired  (tmr_zero[k])
        );

        // R8: terminate only when expired and grant withdrawn
        always_comb begin
            must_end[k] = bus_active && is_owner && tmr_zero[k] && !cur_oh[k];
        end
    end

    // outputs
    always_comb begin
        gnt_n = ~cur_oh;
    end
endmodule

// File: rtl/tenure_arbiter_chk.sv
module tenure_arbiter_chk #(
    parameter int N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_n,
    input logic                 frame_n,
    input logic                 irdy_n,
    input logic [N_MASTERS-1:0] gnt_n,
    input logic [N_MASTERS-1:0] must_end
);
    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    p_first_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n == '1 && req_n != '1) |=> (gnt_n != '1));

    p_grant_to_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gnt_n) |-> ((~gnt_n & ~$past(req_n)) != '0));

    p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n == '1) |=> $stable(gnt_n));

    p_end_needs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (must_end & ~gnt_n) == '0);

    p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |=> (must_end == '0));

    p_single_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(must_end));
endmodule

bind tenure_arbiter tenure_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .gnt_n    (gnt_n),
    .must_end (must_end)
);

// File: tb/tenure_arbiter_tb.sv
module tenure_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int TW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_n = '1;
    logic            frame_n = 1'b1;
    logic            irdy_n = 1'b1;
    logic [N*TW-1:0] lat_cfg = '0;
    logic [N-1:0]    gnt_n;
    logic [N-1:0]    must_end;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st;
    int m_g;
    bit m_gv;
    int m_pg;
    bit m_pgv;
    bit m_busy;
    int m_owner;
    bit m_ov;
    int m_tmr [N];

    // bench bus master state
    bit           b_act;
    bit           b_last;
    int           b_len;
    logic [N-1:0] prev_gnt_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    tenure_arbiter #(.N_MASTERS(N), .TMR_W(TW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .lat_reload (lat_cfg),
        .gnt_n      (gnt_n),
        .must_end   (must_end)
    );

    function automatic int pick(logic [N-1:0] r, int base);
        for (int off = 1; off <= N; off++) begin
            if (r[(base + off) % N]) return (base + off) % N;
        end
        return base;
    endfunction

    function automatic logic [N-1:0] exp_gnt();
        logic [N-1:0] v;
        v = '1;
        if (m_gv) v[m_g] = 1'b0;
        return v;
    endfunction

    function automatic logic [N-1:0] exp_end();
        logic [N-1:0] v;
        v = '0;
        for (int k = 0; k < N; k++)
            if (m_busy && m_ov && m_owner == k && m_tmr[k] == 0 && !(m_gv && m_g == k))
                v[k] = 1'b1;
        return v;
    endfunction

    task automatic model_reset();
        m_st = 0; m_g = N - 1; m_gv = 0; m_pg = 0; m_pgv = 0;
        m_busy = 0; m_owner = 0; m_ov = 0;
        for (int k = 0; k < N; k++) m_tmr[k] = 0;
    endtask

    task automatic model_tick();
        logic [N-1:0] reqv, cur, others;
        bit start, old_pgv;
        int old_pg;
        reqv  = ~req_n;
        start = !m_busy && !frame_n;
        // R7/R10 timer and owner
        if (start && m_pgv) begin
            m_owner = m_pg; m_ov = 1;
            m_tmr[m_pg] = int'(lat_cfg[m_pg*TW +: TW]);
        end else if (m_busy && m_ov && m_tmr[m_owner] != 0) begin
            m_tmr[m_owner] = m_tmr[m_owner] - 1;
        end
        // R9 bus tracking
        if (!m_busy) m_busy = !frame_n;
        else         m_busy = !(frame_n && irdy_n);
        // R2..R6 grant
        cur = '0;
        if (m_gv) cur[m_g] = 1'b1;
        others  = reqv & ~cur;
        old_pg  = m_pg; old_pgv = m_pgv;
        m_pg    = m_g;  m_pgv   = m_gv;
        case (m_st)
            0: if (reqv != '0) begin m_g = pick(reqv, m_g); m_gv = 1; m_st = 1; end
            1: begin
                if (others != '0 && !reqv[m_g]) m_g = pick(reqv, m_g);
                else if (start && old_pgv && old_pg == m_g) m_st = 2;
            end
            default: if (others != '0) begin m_g = pick(reqv, m_g); m_st = 1; end
        endcase
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R2/R3/R4/R5/R6 grant vs model", 32'(gnt_n), 32'(exp_gnt()));
        chk("R7/R8/R9/R10 terminate vs model", 32'(must_end), 32'(exp_end()));
    endtask

    task automatic bus_auto();
        if (!b_act) begin
            if (prev_gnt_seen != '1 && frame_n && irdy_n && ($urandom % 4 != 0)) begin
                frame_n = 1'b0; irdy_n = 1'b0;
                b_act = 1; b_last = 0; b_len = 1 + int'($urandom % 16);
            end
        end else if (b_last) begin
            irdy_n = 1'b1; b_act = 0;
        end else if (b_len <= 1 || must_end != '0) begin
            frame_n = 1'b1; b_last = 1;
        end else begin
            b_len--;
        end
        prev_gnt_seen = gnt_n;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 gnt_n in reset", 32'(gnt_n), 32'(4'b1111));
        chk("R1 must_end in reset", 32'(must_end), 32'h0);
        rst_n = 1'b1;
        chk("R1 gnt_n after reset", 32'(gnt_n), 32'(4'b1111));

        // R3: masters 0,1,2 request from reset, master 0 wins
        lat_cfg[0*TW +: TW] = 8'd3;
        lat_cfg[2*TW +: TW] = 8'd5;
        req_n = 4'b1000;
        step();
        chk("R3 first grant to master 0", 32'(gnt_n), 32'(4'b1110));

        // R6: grantee still requesting, not started: holds
        repeat (3) step();
        chk("R6 pending grantee holds", 32'(gnt_n), 32'(4'b1110));

        // R4: no requests, grant parks
        req_n = 4'b1111;
        repeat (2) step();
        chk("R4 park on master 0", 32'(gnt_n), 32'(4'b1110));

        // master 0 starts a long burst, nobody else requests
        frame_n = 1'b0; irdy_n = 1'b0;
        step();
        repeat (6) step();
        chk("R8 expired but still granted", 32'(must_end), 32'h0);

        // R5: master 2 requests during the burst
        req_n = 4'b1011;
        step();
        chk("R5 hidden handoff to master 2", 32'(gnt_n), 32'(4'b1011));
        chk("R8 terminate to owner 0", 32'(must_end), 32'(4'b0001));
        frame_n = 1'b1;
        step();
        irdy_n = 1'b1;
        step();
        chk("R9 idle clears terminate", 32'(must_end), 32'h0);

        // R7/R10: master 2 starts with reload 5, master 1 waiting
        req_n = 4'b1001;
        frame_n = 1'b0; irdy_n = 1'b0;
        step();
        chk("R6 grantee keeps grant on start", 32'(gnt_n), 32'(4'b1011));
        step();
        chk("R5 handoff to master 1", 32'(gnt_n), 32'(4'b1101));
        repeat (3) step();
        chk("R7 one clock before expiry", 32'(must_end), 32'h0);
        step();
        chk("R7 R10 expiry on owner 2", 32'(must_end), 32'(4'b0100));
        frame_n = 1'b1;
        step();
        irdy_n = 1'b1;
        req_n = 4'b1111;
        step();
        chk("R9 release", 32'(must_end), 32'h0);

        // random phase
        for (int k = 0; k < N; k++) lat_cfg[k*TW +: TW] = TW'($urandom % 16);
        b_act = 0; b_last = 0; b_len = 0;
        prev_gnt_seen = '1;
        for (int c = 0; c < 4000; c++) begin
            for (int k = 0; k < N; k++)
                if ($urandom % 5 == 0) req_n[k] = ~req_n[k];
            if (c % 1000 == 999)
                for (int k = 0; k < N; k++) lat_cfg[k*TW +: TW] = TW'($urandom % 12);
            bus_auto();
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule